// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a set of general-purpose pins and turns a programmed condition on each one into a latched status bit. Each pin selects its condition with two configuration bits. One chooses edge or level detection. The other picks the polarity. The polarity encoding is asymmetric: with the polarity bit clear, edge mode fires on a rising edge but level mode fires on a low level. With the polarity bit set, edge mode fires on a falling edge and level mode fires on a high level. Edge detection compares the synchronized level with the level seen one cycle earlier. A pin whose input sensing is off, or which is not in GPIO mode, never raises status.

A status bit stays set until software clears it with a write-one mask. If a new condition arrives in the same cycle as the clear, the new condition wins, so an edge that follows a clear-before-service is never lost. In level mode the condition is re-applied every cycle, so clearing a bit while its level is still active leaves the bit set.

A pin is pending when its status bit and its enable bit are both set. The block ORs every pending pin into one registered interrupt output. For each 32-pin bank it also gives the index of the lowest-numbered pending pin, with a valid flag. Software can then service pins lowest-first.

Top module: `gpio_irq_detect`

## Requirements
- R1: With trig_level=0 and trig_inv=0, a 0-to-1 change of pin_level between two consecutive clock edges sets that pin's status bit at the second edge.
- R2: With trig_level=0 and trig_inv=1, a 1-to-0 change of pin_level sets the status bit, and a 0-to-1 change does not.
- R3: With trig_level=1 and trig_inv=0, status is set at every clock edge where pin_level is 0. A clear applied while the level is still low leaves the bit set.
- R4: With trig_level=1 and trig_inv=1, status is set at every clock edge where pin_level is 1, and not while pin_level is 0.
- R5: A pin with sense_on=0 or gpio_mode=0 never has its status bit newly set, whatever its level or edges.
- R6: A set status bit stays set until a clock edge where clr_valid=1 and its bit of clr_mask is 1. Clearing one bit leaves all other bits unchanged.
- R7: When a detection and a clear of the same pin fall on the same clock edge, the status bit ends up set.
- R8: irq_out is, one clock after any given edge, the OR over all pins of (status AND irq_en) as it stood at that edge.
- R9: For bank b (pins 32b to 32b+31), bank_vld[b] and bank_idx[5b+4:5b] give, with the same one-cycle latency as irq_out, whether any pin of the bank is pending and the offset within the bank of the lowest-numbered pending pin.
- R10: During and right after a synchronous reset, status is all zero, irq_out is 0 and every bank_vld bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PINS | Synchronized pin levels |
| gpio_mode | input | NUM_PINS | 1: pin used as GPIO (detection allowed) |
| sense_on | input | NUM_PINS | 1: input sensing enabled |
| trig_level | input | NUM_PINS | 0: edge detection, 1: level detection |
| trig_inv | input | NUM_PINS | Polarity bit, encoding as in R1 to R4 |
| irq_en | input | NUM_PINS | Per-pin interrupt enable |
| clr_valid | input | 1 | Qualifies clr_mask for this cycle |
| clr_mask | input | NUM_PINS | Write-one-to-clear mask for status |
| status | output | NUM_PINS | Sticky per-pin status |
| irq_out | output | 1 | Registered OR of all pending pins |
| bank_idx | output | 5*BANKS | Lowest pending offset per bank, 5 bits per bank |
| bank_vld | output | BANKS | Per-bank any-pending flag |

## Verification
Directed steps try each of the four trigger encodings with the opposite stimulus, for example a rising edge on a falling-edge pin, so that a swapped polarity or mode decode shows up. Clears are applied while a low level is still active and at the same time as a fresh edge; these separate set-over-clear priority from a plain sticky register. Enables are set on pins in both banks, one bank only partly filled, and then cleared one by one to check the lowest-first index. A long random phase then toggles pins sparsely and varies the configuration, gating and clear masks, and compares all outputs every cycle against a bench model.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int BANK_W = 32;
  localparam int IDX_W  = 5;

  typedef struct packed {
    logic             found;
    logic [IDX_W-1:0] idx;
  } lowest_t;

  // Scan from the top down so the last hit kept is the lowest set bit.
  function automatic lowest_t lowest_set(input logic [BANK_W-1:0] v);
    lowest_t r;
    r.found = 1'b0;
    r.idx   = '0;
    for (int i = BANK_W - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.found = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irqd_pin_detect.sv
module irqd_pin_detect #(
  parameter int NUM_PINS = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] gpio_mode,
  input  logic [NUM_PINS-1:0] sense_on,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic [NUM_PINS-1:0] clr_eff,
  output logic [NUM_PINS-1:0] status
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;

  // The previous level follows the pin even in reset, so no edge appears on release.
  always_ff @(posedge clk) prev_q <= pin_level;

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      logic armed, rise, fall, edge_hit, lvl_hit;
      always_comb begin
        armed    = gpio_mode[p] & sense_on[p];
        rise     = pin_level[p] & ~prev_q[p];
        fall     = ~pin_level[p] & prev_q[p];
        edge_hit = trig_inv[p] ? fall : rise;
        lvl_hit  = ~(pin_level[p] ^ trig_inv[p]);
        hit[p]   = armed & (trig_level[p] ? lvl_hit : edge_hit);
      end
    end
  endgenerate

  // A detection wins over a clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | hit;
  end

  logic [NUM_PINS-1:0] chk_rise, chk_low, chk_keep;
  assign chk_rise = gpio_mode & sense_on & ~trig_level & ~trig_inv & pin_level & ~prev_q;
  assign chk_low  = gpio_mode & sense_on & trig_level & ~trig_inv & ~pin_level;
  assign chk_keep = status & ~clr_eff;

  assert_rise_sets_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(chk_rise)) == $past(chk_rise)));

  assert_low_level_sets_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(chk_low)) == $past(chk_low)));

  assert_gated_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(gpio_mode & sense_on)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(chk_keep)) == $past(chk_keep)));
endmodule

// File: rtl/irqd_bank_encode.sv
module irqd_bank_encode
  import irqd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] pend,
  output logic [IDX_W-1:0]  idx,
  output logic              vld
);
  lowest_t low;
  always_comb low = lowest_set(pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      vld <= 1'b0;
    end else begin
      idx <= low.idx;
      vld <= low.found;
    end
  end

  assert_vld_any_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vld == (|$past(pend))));

  assert_idx_pending_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!vld || ((($past(pend) >> idx) & 32'd1) != 32'd0)));

  assert_idx_lowest_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!vld || (($past(pend) & ((32'd1 << idx) - 32'd1)) == 32'd0)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 48,
  localparam int BANKS   = (NUM_PINS + BANK_W - 1) / BANK_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PINS-1:0]    pin_level,
  input  logic [NUM_PINS-1:0]    gpio_mode,
  input  logic [NUM_PINS-1:0]    sense_on,
  input  logic [NUM_PINS-1:0]    trig_level,
  input  logic [NUM_PINS-1:0]    trig_inv,
  input  logic [NUM_PINS-1:0]    irq_en,
  input  logic                   clr_valid,
  input  logic [NUM_PINS-1:0]    clr_mask,
  output logic [NUM_PINS-1:0]    status,
  output logic                   irq_out,
  output logic [IDX_W*BANKS-1:0] bank_idx,
  output logic [BANKS-1:0]       bank_vld
);
  logic [NUM_PINS-1:0] clr_eff;
  logic [NUM_PINS-1:0] pending;

  assign clr_eff = clr_valid ? clr_mask : '0;

  irqd_pin_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .pin_level  (pin_level),
    .gpio_mode  (gpio_mode),
    .sense_on   (sense_on),
    .trig_level (trig_level),
    .trig_inv   (trig_inv),
    .clr_eff    (clr_eff),
    .status     (status)
  );

  assign pending = status & irq_en;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pending;
  end

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      localparam int LO = b * BANK_W;
      localparam int W  = (NUM_PINS - LO < BANK_W) ? (NUM_PINS - LO) : BANK_W;
      logic [BANK_W-1:0] slice;
      always_comb begin
        slice      = '0;
        slice[W-1:0] = pending[LO +: W];
      end
      irqd_bank_encode u_enc (
        .clk  (clk),
        .rst  (rst),
        .pend (slice),
        .idx  (bank_idx[b*IDX_W +: IDX_W]),
        .vld  (bank_vld[b])
      );
    end
  endgenerate

  assert_irq_out_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == (|$past(status & irq_en))));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (status == '0 && !irq_out && bank_vld == '0));
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 48;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pin, gm, se, tl, ti, en, clr_m;
  logic clr_v;
  logic [N-1:0] status;
  logic irq_out;
  logic [5*NB-1:0] bank_idx;
  logic [NB-1:0] bank_vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [N-1:0] m_prev, m_stat;
  logic m_irq;
  logic [4:0] m_idx [NB];
  logic m_vld [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst(rst), .pin_level(pin), .gpio_mode(gm), .sense_on(se),
    .trig_level(tl), .trig_inv(ti), .irq_en(en), .clr_valid(clr_v),
    .clr_mask(clr_m), .status(status), .irq_out(irq_out),
    .bank_idx(bank_idx), .bank_vld(bank_vld)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic detect(input logic p, input logic pv, input logic g,
                                  input logic s, input logic l, input logic i);
    logic cond;
    if (l) cond = i ? p : ~p;
    else   cond = i ? (pv & ~p) : (~pv & p);
    return g & s & cond;
  endfunction

  task automatic model_step();
    logic [N-1:0] pend, ev, clr;
    pend = m_stat & en;
    m_irq = |pend;
    for (int b = 0; b < NB; b++) begin
      bit found = 0;
      m_idx[b] = '0;
      for (int k = 0; k < 32; k++) begin
        if (!found && (b*32 + k) < N && pend[b*32 + k]) begin
          found = 1;
          m_idx[b] = 5'(k);
        end
      end
      m_vld[b] = found;
    end
    for (int k = 0; k < N; k++) ev[k] = detect(pin[k], m_prev[k], gm[k], se[k], tl[k], ti[k]);
    clr = clr_v ? clr_m : '0;
    m_stat = (m_stat & ~clr) | ev;
    m_prev = pin;
  endtask

  task automatic compare_all();
    check("R6 status vs model", 64'(status), 64'(m_stat));
    check("R8 irq_out vs model", 64'(irq_out), 64'(m_irq));
    for (int b = 0; b < NB; b++) begin
      check("R9 bank_vld vs model", 64'(bank_vld[b]), 64'(m_vld[b]));
      if (m_vld[b]) check("R9 bank_idx vs model", 64'(bank_idx[b*5 +: 5]), 64'(m_idx[b]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    clr_v = 1'b0;
    compare_all();
  endtask

  task automatic clear_bit(input int k);
    clr_m = '0;
    clr_m[k] = 1'b1;
    clr_v = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd20240611));
    pin = '0; gm = '1; se = '1; tl = '0; ti = '0; en = '0;
    clr_v = 1'b0; clr_m = '0;
    m_prev = '0; m_stat = '0; m_irq = 1'b0;
    for (int b = 0; b < NB; b++) begin m_idx[b] = '0; m_vld[b] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R10 status in reset", 64'(status), 64'd0);
    check("R10 irq_out in reset", 64'(irq_out), 64'd0);
    check("R10 bank_vld in reset", 64'(bank_vld), 64'd0);
    rst = 1'b0;
    m_prev = pin;
    tick();
    check("R10 status after reset", 64'(status), 64'd0);

    // R1: rising edge on pin 3
    pin[3] = 1'b1; tick();
    check("R1 rising edge sets pin3", 64'(status[3]), 64'd1);
    pin[3] = 1'b0; tick(); tick();
    check("R6 pin3 sticky after fall", 64'(status[3]), 64'd1);

    // R8/R9: enable pin 3
    en[3] = 1'b1; tick();
    check("R8 irq_out with pin3 pending", 64'(irq_out), 64'd1);
    check("R9 bank0 idx pin3", 64'(bank_idx[4:0]), 64'd3);

    // R2: falling edge on pin 40 (bank 1 offset 8)
    ti[40] = 1'b1; pin[40] = 1'b1; tick();
    check("R2 rising ignored on falling pin40", 64'(status[40]), 64'd0);
    pin[40] = 1'b0; tick();
    check("R2 falling edge sets pin40", 64'(status[40]), 64'd1);
    en[40] = 1'b1; tick();
    check("R9 bank1 idx offset 8", 64'(bank_idx[9:5]), 64'd8);
    check("R9 bank1 valid", 64'(bank_vld[1]), 64'd1);

    // R6: clear one bit
    clear_bit(3); tick();
    check("R6 clear pin3", 64'(status[3]), 64'd0);
    check("R6 clear leaves pin40", 64'(status[40]), 64'd1);
    tick();
    check("R9 bank0 empty after clear", 64'(bank_vld[0]), 64'd0);
    check("R8 irq_out still from pin40", 64'(irq_out), 64'd1);

    // R7: clear and rising edge together on pin 5
    pin[5] = 1'b1; clear_bit(5); tick();
    check("R7 edge wins over clear pin5", 64'(status[5]), 64'd1);

    // R3: low level on pin 10
    tl[10] = 1'b1; tick();
    check("R3 low level sets pin10", 64'(status[10]), 64'd1);
    clear_bit(10); tick();
    check("R3 clear during low level re-sets", 64'(status[10]), 64'd1);
    pin[10] = 1'b1; tick();
    clear_bit(10); tick();
    check("R3 clear after level gone", 64'(status[10]), 64'd0);

    // R4: high level on pin 11
    tl[11] = 1'b1; ti[11] = 1'b1; tick();
    check("R4 low ignored on high-level pin11", 64'(status[11]), 64'd0);
    pin[11] = 1'b1; tick();
    check("R4 high level sets pin11", 64'(status[11]), 64'd1);

    // R5: gating
    se[12] = 1'b0; pin[12] = 1'b1; tick();
    check("R5 sensing off pin12", 64'(status[12]), 64'd0);
    gm[13] = 1'b0; pin[13] = 1'b1; tick();
    check("R5 not gpio pin13", 64'(status[13]), 64'd0);
    gm[14] = 1'b0; tl[14] = 1'b1; tick(); tick();
    check("R5 level gated pin14", 64'(status[14]), 64'd0);
    gm[13] = 1'b1; se[12] = 1'b1; gm[14] = 1'b1; tl[14] = 1'b0;

    // R9: lowest first among pins 5 and 11
    en[5] = 1'b1; en[11] = 1'b1; tick(); tick();
    check("R9 lowest is pin5", 64'(bank_idx[4:0]), 64'd5);
    clear_bit(5); tick(); tick();
    check("R9 next lowest is pin11", 64'(bank_idx[4:0]), 64'd11);

    // Random phase against the model (R1-R9 together)
    for (int c = 0; c < 3000; c++) begin
      r = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      pin = pin ^ r[N-1:0];
      if (c % 16 == 0) begin
        r = {$urandom(), $urandom()}; tl = r[N-1:0] & {$urandom(), $urandom()};
        r = {$urandom(), $urandom()}; ti = r[N-1:0];
        r = {$urandom(), $urandom()}; en = r[N-1:0];
        r = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
        gm = ~r[N-1:0];
        r = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
        se = ~r[N-1:0];
      end
      if ($urandom() % 3 == 0) begin
        if ($urandom() % 2 == 0) clear_bit(int'($urandom() % N));
        else begin
          r = {$urandom(), $urandom()};
          clr_m = r[N-1:0];
          clr_v = 1'b1;
        end
      end
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule